// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a host and a parallel NOR flash bank that uses a command-register protocol. The host asks for one of four operations (word program, block erase, block lock, block unlock) by presenting an operation code, a word address and a data word for one cycle while the block is idle. The sequencer then plays a fixed script of command write cycles on the flash bus, one write strobe per cycle. Where the device works in the background, it reads the status register repeatedly until the device reports ready, or until a cycle budget runs out.

The flash data bus may be built from several 16-bit devices placed side by side. Every command byte is therefore copied into the low byte of each 16-bit lane, and the upper byte of each lane is zero. A status condition counts as ready only when every lane reports it. Every operation that reaches the device ends with a clear-status write and then a read-array write, so the bank reads as memory again afterwards. The outcome comes back as a two-bit code that is valid while a one-cycle done pulse is high.

Top module: `nor_cmd_seq`

## Requirements
- R1: A program request first reads the target word. It then writes 0x50, 0xFF, 0x40 and then the host data word, all to the target address, and polls the status at the target address.
- R2: If (current word AND new word) differs from the new word, a program request ends with result 2 and no write cycle on the flash bus.
- R3: An erase request writes 0x50, 0x20 and 0xD0 to the block base address, which is the request address with its low BLK_AW bits cleared.
- R4: After the erase confirm write, no status read is issued for at least MIN_WAIT clock cycles.
- R5: An operation completes when status bit 7 is 1 in every 16-bit lane. A program that completes with status bit 4 set in any lane ends with result 1; otherwise the result is 0.
- R6: If the device has not reported ready after TIMEOUT cycles of polling, the sequencer writes 0xB0 (suspend), then the closing writes, and ends with result 1.
- R7: Lock writes 0x60 then 0x01, and unlock writes 0x60 then 0xD0, both at the block base. The sequencer then writes 0x90 and reads base+2. The result is 0 only when bit 0 of every lane equals the requested state (1 for locked); otherwise it is 1.
- R8: Every operation except the result-2 abort ends its writes with 0x50 and then 0xFF, at the target address for a program and at the block base otherwise.
- R9: Each command byte b is driven as 0x00 followed by b in every 16-bit lane of the data bus (0x00500050 for 0x50 on a 32-bit bus).
- R10: busy goes high in the cycle after a request is accepted and stays high until done. done is a one-cycle pulse while busy is low, and result is valid with it. The operation codes are 0 program, 1 erase, 2 lock and 3 unlock.
- R11: A request made while busy is high is ignored: it causes neither a second done pulse nor any write cycle.
- R12: After reset, busy, done, the write strobe and the read strobe are all low, and the two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Operation request, sampled while idle |
| req_op | input | 2 | 0 program, 1 erase, 2 lock, 3 unlock |
| req_addr | input | AW | Word address |
| req_data | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 fail or timeout, 2 not erased |
| fl_we | output | 1 | Flash write strobe, one write per high cycle |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, valid in the cycle fl_re is high |

## Verification
The bench builds the block with a 32-bit bus (two lanes), an 8-bit word address and 16-word blocks. MIN_WAIT is set to 20 cycles and TIMEOUT to 40. With a budget that small, a device model whose program time is longer than the budget runs into the suspend path within a few dozen cycles. The gap between the erase confirm and the first poll can also be measured exactly. Small blocks let erase, lock and program requests fall in different blocks of a small model memory. Fault injection in the model (an error bit, a lock bit that does not change) covers both failure paths.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_ERASE  = 2'd1,
    OP_LOCK   = 2'd2,
    OP_UNLOCK = 2'd3
  } op_e;

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_FAIL = 2'd1;
  localparam logic [1:0] RES_NERA = 2'd2;

  localparam logic [7:0] CMD_CLR    = 8'h50;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_PSET   = 8'h40;
  localparam logic [7:0] CMD_ESET   = 8'h20;
  localparam logic [7:0] CMD_CONF   = 8'hD0;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_LSET   = 8'h60;
  localparam logic [7:0] CMD_LOCK   = 8'h01;
  localparam logic [7:0] CMD_QUERY  = 8'h90;

  typedef enum logic [1:0] {
    AS_TGT  = 2'd0,
    AS_BASE = 2'd1,
    AS_QRY  = 2'd2
  } asel_e;

  typedef struct packed {
    logic       rd;
    logic       last;
    logic       use_data;
    asel_e      asel;
    logic [7:0] cmd;
  } step_t;

endpackage

// File: rtl/nor_seq_script.sv
module nor_seq_script
  import nor_seq_pkg::*;
(
  input  op_e        op,
  input  logic [2:0] idx,
  output step_t      step
);

  always_comb begin
    step.rd       = 1'b0;
    step.last     = 1'b0;
    step.use_data = 1'b0;
    step.asel     = AS_BASE;
    step.cmd      = CMD_CLR;
    unique case (op)
      OP_PROG: begin
        step.asel = AS_TGT;
        case (idx)
          3'd0:    step.rd  = 1'b1;
          3'd1:    step.cmd = CMD_CLR;
          3'd2:    step.cmd = CMD_ARRAY;
          3'd3:    step.cmd = CMD_PSET;
          default: begin
            step.use_data = 1'b1;
            step.last     = 1'b1;
          end
        endcase
      end
      OP_ERASE: begin
        case (idx)
          3'd0:    step.cmd = CMD_CLR;
          3'd1:    step.cmd = CMD_ESET;
          default: begin
            step.cmd  = CMD_CONF;
            step.last = 1'b1;
          end
        endcase
      end
      default: begin
        case (idx)
          3'd0:    step.cmd = CMD_LSET;
          3'd1:    step.cmd = (op == OP_LOCK) ? CMD_LOCK : CMD_CONF;
          3'd2:    step.cmd = CMD_QUERY;
          default: begin
            step.rd   = 1'b1;
            step.asel = AS_QRY;
            step.last = 1'b1;
          end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic          hit
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (cnt != {CW{1'b1}})
      cnt <= cnt + 1'b1;
  end

  assign hit = (cnt >= lim);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW       = 22,
  parameter int DW       = 32,
  parameter int BLK_AW   = 15,
  parameter int MIN_WAIT = 50000,
  parameter int TIMEOUT  = 500000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata
);

  localparam int LANES = DW / 16;
  localparam int LIMV  = (MIN_WAIT > TIMEOUT) ? MIN_WAIT : TIMEOUT;
  localparam int CW    = $clog2(LIMV + 1);

  function automatic logic [DW-1:0] rep(input logic [7:0] b);
    rep = {LANES{{8'h00, b}}};
  endfunction

  typedef enum logic [3:0] {
    S_IDLE, S_STEP, S_RDW, S_WAIT, S_POLL, S_POLLW, S_SUSP, S_CLR, S_RDA, S_FIN
  } st_e;

  st_e           state;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [2:0]    idx;
  logic [1:0]    res_q;
  step_t         st;
  logic          hit, tmr_clr;
  logic [CW-1:0] tmr_lim;
  logic [AW-1:0] base, qaddr, step_addr, op_addr;
  logic [LANES-1:0] ln_rdy, ln_err, ln_lk;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ln_rdy[g] = fl_rdata[16*g + 7];
    assign ln_err[g] = fl_rdata[16*g + 4];
    assign ln_lk[g]  = fl_rdata[16*g];
  end

  assign base  = {addr_q[AW-1:BLK_AW], {BLK_AW{1'b0}}};
  assign qaddr = base | AW'(2);

  always_comb begin
    unique case (st.asel)
      AS_TGT:  step_addr = addr_q;
      AS_QRY:  step_addr = qaddr;
      default: step_addr = base;
    endcase
  end

  assign op_addr = (op_q == OP_PROG) ? addr_q : base;

  nor_seq_script u_script (
    .op   (op_q),
    .idx  (idx),
    .step (st)
  );

  assign tmr_clr = (state == S_IDLE) ||
                   (state == S_STEP && !st.rd && st.last) ||
                   (state == S_WAIT && hit);
  assign tmr_lim = (state == S_WAIT) ? CW'(MIN_WAIT) : CW'(TIMEOUT);

  nor_seq_timer #(.CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .lim (tmr_lim),
    .hit (hit)
  );

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= OP_PROG;
      addr_q   <= '0;
      data_q   <= '0;
      idx      <= '0;
      res_q    <= RES_OK;
      done     <= 1'b0;
      result   <= RES_OK;
      fl_we    <= 1'b0;
      fl_re    <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
    end else begin
      fl_we <= 1'b0;
      fl_re <= 1'b0;
      done  <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q   <= op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            idx    <= '0;
            res_q  <= RES_OK;
            state  <= S_STEP;
          end
        end
        S_STEP: begin
          fl_addr <= step_addr;
          if (st.rd) begin
            fl_re <= 1'b1;
            state <= S_RDW;
          end else begin
            fl_we    <= 1'b1;
            fl_wdata <= st.use_data ? data_q : rep(st.cmd);
            if (st.last)
              state <= (op_q == OP_ERASE) ? S_WAIT : S_POLL;
            else
              idx <= idx + 1'b1;
          end
        end
        S_RDW: begin
          if (op_q == OP_PROG) begin
            if ((fl_rdata & data_q) != data_q) begin
              res_q <= RES_NERA;
              state <= S_FIN;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_STEP;
            end
          end else begin
            if ((op_q == OP_LOCK) ? (&ln_lk) : (~|ln_lk))
              res_q <= RES_OK;
            else
              res_q <= RES_FAIL;
            state <= S_CLR;
          end
        end
        S_WAIT: begin
          if (hit) state <= S_POLL;
        end
        S_POLL: begin
          fl_re   <= 1'b1;
          fl_addr <= op_addr;
          state   <= S_POLLW;
        end
        S_POLLW: begin
          if (&ln_rdy) begin
            res_q <= (op_q == OP_PROG && |ln_err) ? RES_FAIL : RES_OK;
            state <= S_CLR;
          end else if (hit) begin
            state <= S_SUSP;
          end else begin
            state <= S_POLL;
          end
        end
        S_SUSP: begin
          fl_we    <= 1'b1;
          fl_addr  <= op_addr;
          fl_wdata <= rep(CMD_SUSP);
          res_q    <= RES_FAIL;
          state    <= S_CLR;
        end
        S_CLR: begin
          fl_we    <= 1'b1;
          fl_addr  <= op_addr;
          fl_wdata <= rep(CMD_CLR);
          state    <= S_RDA;
        end
        S_RDA: begin
          fl_we    <= 1'b1;
          fl_addr  <= op_addr;
          fl_wdata <= rep(CMD_ARRAY);
          state    <= S_FIN;
        end
        default: begin
          done   <= 1'b1;
          result <= res_q;
          state  <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic [1:0]    result,
  input logic          fl_we,
  input logic          fl_re,
  input logic [DW-1:0] fl_wdata
);

  localparam int LANES = DW / 16;
  localparam logic [DW-1:0] W_ARRAY = {LANES{16'h00FF}};
  localparam logic [DW-1:0] W_SUSP  = {LANES{16'h00B0}};
  localparam logic [DW-1:0] W_CLR   = {LANES{16'h0050}};

  logic [3:0] wr_n;

  always_ff @(posedge clk) begin
    if (rst)
      wr_n <= '0;
    else if (req_valid && !busy)
      wr_n <= '0;
    else if (fl_we && wr_n != 4'hF)
      wr_n <= wr_n + 1'b1;
  end

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r11_busy_from_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  a_r2_no_writes: assert property (@(posedge clk) disable iff (rst)
    (done && result == 2'd2) |-> (wr_n == 4'd0));

  a_r8_ends_array: assert property (@(posedge clk) disable iff (rst)
    (done && result != 2'd2) |-> $past(fl_we && fl_wdata == W_ARRAY));

  a_r6_susp_then_clr: assert property (@(posedge clk) disable iff (rst)
    (fl_we && fl_wdata == W_SUSP && !$past(fl_we)) |=> (fl_we && fl_wdata == W_CLR));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .fl_we    (fl_we),
  .fl_re    (fl_re),
  .fl_wdata (fl_wdata)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BLK_AW = 4;
  localparam int MIN_WAIT = 20;
  localparam int TIMEOUT = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          busy, done, fl_we, fl_re;
  logic [1:0]    result;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata, fl_rdata;

  nor_cmd_seq #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW), .MIN_WAIT(MIN_WAIT), .TIMEOUT(TIMEOUT)) u_nor_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .done(done), .result(result), .fl_we(fl_we),
    .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata));

  // ---------------- flash device model ----------------
  logic [31:0] mem [256];
  logic [15:0] lkb;
  int          busy_c;
  logic        err_f;
  logic [1:0]  mode;   // 0 array, 1 status, 2 query
  logic [1:0]  pend;   // 0 none, 1 program, 2 erase, 3 lock
  int          prog_lat = 5;
  logic        inj_err = 1'b0;
  logic        lk_stuck = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hFFFF_FFFF;
      lkb <= '0; busy_c <= 0; err_f <= 1'b0; mode <= 2'd0; pend <= 2'd0;
    end else begin
      if (busy_c > 0) busy_c <= busy_c - 1;
      if (fl_we) begin
        if (pend == 2'd1) begin
          mem[fl_addr] <= mem[fl_addr] & fl_wdata;
          busy_c <= prog_lat; err_f <= inj_err; mode <= 2'd1; pend <= 2'd0;
        end else if (pend == 2'd2) begin
          if (fl_wdata[7:0] == 8'hD0)
            for (int i = 0; i < 16; i++) mem[{fl_addr[7:4], 4'(i)}] <= 32'hFFFF_FFFF;
          busy_c <= 8; mode <= 2'd1; pend <= 2'd0;
        end else if (pend == 2'd3) begin
          if (!lk_stuck) lkb[fl_addr[7:4]] <= (fl_wdata[7:0] == 8'h01);
          mode <= 2'd1; pend <= 2'd0;
        end else begin
          case (fl_wdata[7:0])
            8'h50: err_f <= 1'b0;
            8'hFF: mode <= 2'd0;
            8'h40: pend <= 2'd1;
            8'h20: pend <= 2'd2;
            8'h60: pend <= 2'd3;
            8'h90: mode <= 2'd2;
            default: mode <= 2'd1;
          endcase
        end
      end
    end
  end

  logic [15:0] st16;
  always_comb begin
    st16 = {8'h00, (busy_c == 0), 2'b00, err_f, 4'h0};
    case (mode)
      2'd0:    fl_rdata = mem[fl_addr];
      2'd1:    fl_rdata = {st16, st16};
      default: fl_rdata = (fl_addr[3:0] == 4'd2) ? {2{15'b0, lkb[fl_addr[7:4]]}} : '0;
    endcase
  end

  // ---------------- bus monitor ----------------
  logic [7:0]  wl_a [1024];
  logic [31:0] wl_d [1024];
  logic [7:0]  rl_a [1024];
  int wn = 0, rn = 0, dn = 0, cyc = 0, d0c = 0, gap = -1;
  logic armed = 1'b0;
  logic [7:0] prevc = 8'h00;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (done) dn = dn + 1;
      if (fl_we) begin
        wl_a[wn % 1024] = fl_addr; wl_d[wn % 1024] = fl_wdata; wn = wn + 1;
        if (fl_wdata[7:0] == 8'hD0 && prevc == 8'h20) begin armed = 1'b1; d0c = cyc; end
        prevc = fl_wdata[7:0];
      end
      if (fl_re) begin
        rl_a[rn % 1024] = fl_addr; rn = rn + 1;
        if (armed) begin gap = cyc - d0c; armed = 1'b0; end
      end
    end
  end

  // ---------------- checking helpers ----------------
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rp(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  logic [7:0]  ex_a [16];
  logic [31:0] ex_d [16];
  int ex_n;

  task automatic push(input logic [7:0] a, input logic [31:0] d);
    ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
  endtask

  // expected write script from the requirements
  task automatic build_exp(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d,
                           input logic [1:0] res, input bit tmo);
    logic [7:0] b;
    b = {a[7:4], 4'h0};
    ex_n = 0;
    if (op == 2'd0) begin
      if (res != 2'd2) begin
        push(a, rp(8'h50)); push(a, rp(8'hFF)); push(a, rp(8'h40)); push(a, d);
        if (tmo) push(a, rp(8'hB0));
        push(a, rp(8'h50)); push(a, rp(8'hFF));
      end
    end else if (op == 2'd1) begin
      push(b, rp(8'h50)); push(b, rp(8'h20)); push(b, rp(8'hD0));
      push(b, rp(8'h50)); push(b, rp(8'hFF));
    end else begin
      push(b, rp(8'h60)); push(b, rp((op == 2'd2) ? 8'h01 : 8'hD0)); push(b, rp(8'h90));
      push(b, rp(8'h50)); push(b, rp(8'hFF));
    end
  endtask

  int wb, rb, db;

  task automatic cmp_writes(input string req);
    int bad;
    bad = -1;
    chk((wn - wb) == ex_n, req, "write count", wn - wb, ex_n);
    for (int i = 0; i < ex_n; i++)
      if (bad < 0 && (i >= wn - wb || wl_a[(wb + i) % 1024] != ex_a[i] || wl_d[(wb + i) % 1024] != ex_d[i]))
        bad = i;
    if (bad >= 0 && bad < wn - wb)
      chk(1'b0, req, "write data", wl_d[(wb + bad) % 1024], ex_d[bad]);
    else
      chk(bad < 0, req, "write sequence", bad, -1);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d,
                       input bit poke, output logic [1:0] res);
    int k;
    wb = wn; rb = rn; db = dn;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10", "busy after accept", busy, 1);
    k = 0;
    while (!done && k < 3000) begin
      req_valid = (poke && k == 3);
      if (poke && k == 3) begin req_op = 2'd1; req_addr = a; end
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    chk(k < 3000, "R10", "done seen", k, 0);
    res = result;
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
  endtask

  // ---------------- stimulus table ----------------
  localparam int NV = 9;
  localparam logic [1:0]  V_OP [NV] = '{2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1, 2'd0};
  localparam logic [7:0]  V_AD [NV] = '{8'h13, 8'h15, 8'h15, 8'h15, 8'h27, 8'h22, 8'h22, 8'h15, 8'h15};
  localparam logic [31:0] V_DT [NV] = '{32'h0, 32'h12345678, 32'h10305070, 32'hFFFF0000,
                                         32'hA5A5A5A5, 32'h0, 32'h0, 32'h0, 32'hFFFF0000};
  localparam logic        V_ER [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [1:0]  V_RS [NV] = '{2'd0, 2'd0, 2'd0, 2'd2, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0};

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(busy == 1'b0, "R12", "busy at reset", busy, 0);
    chk(done == 1'b0, "R12", "done at reset", done, 0);
    chk(fl_we == 1'b0, "R12", "we at reset", fl_we, 0);
    chk(fl_re == 1'b0, "R12", "re at reset", fl_re, 0);

    for (int v = 0; v < NV; v++) begin
      inj_err = V_ER[v];
      gap = -1;
      do_op(V_OP[v], V_AD[v], V_DT[v], 1'b0, r);
      inj_err = 1'b0;
      chk(r == V_RS[v], (V_OP[v] == 2'd0) ? "R5" : ((V_OP[v] == 2'd1) ? "R3" : "R7"), "result", r, V_RS[v]);
      build_exp(V_OP[v], V_AD[v], V_DT[v], V_RS[v], 1'b0);
      if (V_RS[v] == 2'd2) begin
        cmp_writes("R2");
      end else if (V_OP[v] == 2'd0) begin
        cmp_writes("R1 R8 R9");
        chk(rl_a[rb % 1024] == V_AD[v], "R1", "pre-read address", rl_a[rb % 1024], V_AD[v]);
      end else if (V_OP[v] == 2'd1) begin
        cmp_writes("R3 R8 R9");
        chk(gap >= MIN_WAIT, "R4", "confirm to poll gap", gap, MIN_WAIT);
      end else begin
        cmp_writes("R7 R8");
        chk(rl_a[(rn - 1) % 1024] == {V_AD[v][7:4], 4'h2}, "R7", "query address",
            rl_a[(rn - 1) % 1024], {V_AD[v][7:4], 4'h2});
      end
    end

    // R6: device slower than the polling budget
    prog_lat = 200;
    do_op(2'd0, 8'h30, 32'h0F0F0F0F, 1'b0, r);
    chk(r == 2'd1, "R6", "timeout result", r, 1);
    build_exp(2'd0, 8'h30, 32'h0F0F0F0F, 2'd1, 1'b1);
    cmp_writes("R6");
    repeat (220) @(negedge clk);
    prog_lat = 5;

    // R11: request while busy is ignored
    do_op(2'd0, 8'h31, 32'h0000FFFF, 1'b1, r);
    chk(r == 2'd0, "R11", "result", r, 0);
    chk((dn - db) == 1, "R11", "done pulses", dn - db, 1);
    build_exp(2'd0, 8'h31, 32'h0000FFFF, 2'd0, 1'b0);
    cmp_writes("R11");

    // R7: lock that does not take effect
    lk_stuck = 1'b1;
    do_op(2'd2, 8'h40, 32'h0, 1'b0, r);
    lk_stuck = 1'b0;
    chk(r == 2'd1, "R7", "lock verify fail", r, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule